// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

The sequencer digitizes a sensor array of photodiode channels. The channels sit behind a bank of external 8-way analog multiplexers, and each multiplexer feeds its own parallel-output ADC. One start pulse runs a full scan. For each channel the sequencer selects the ADC and the multiplexer input, then waits a settle time. It then runs the converter handshake: select the chip, pulse the write strobe, wait out the busy flag, and read. The 12-bit result goes into a sample buffer through a simple write port, at an address equal to the channel's position in the scan.

The scan is nested. The ADC select is the slow counter and the multiplexer select is the fast one. The scan stops after `NUM_CH` samples, so the last ADC may be only partly used. With the defaults, 36 channels across 8-input multiplexers fill four ADCs and half of a fifth.

A busy flag that never clears does not hang the block. After a bounded wait the sequencer releases every strobe, abandons the scan and raises a sticky error flag. The next accepted start clears that flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `cs_n`, `wr_n` and `rd_n` are high, `buf_we`, `done` and `err` are low, and `adc_sel` and `mux_sel` are 0.
- R2: Sample k of a scan (k counting from 0) is taken with `adc_sel` = k / `CH_PER_ADC` and `mux_sel` = k % `CH_PER_ADC`. In `mux_sel`, bit 0 drives line A, bit 1 drives line B and bit 2 drives line C.
- R3: Before `cs_n` falls, the selects hold their new value for exactly `SETTLE_CYC` cycles with `cs_n` high. The selects do not change while `cs_n` is low.
- R4: `cs_n` falls one cycle before `wr_n` falls. `wr_n` and `rd_n` are only ever low while `cs_n` is low, and never both at once. `rd_n` is low for exactly one cycle, and `cs_n` rises together with `rd_n`.
- R5: `wr_n` stays low through the write cycle and then until the first clock edge at which `adc_busy` is sampled low. On that edge `wr_n` rises and `rd_n` falls together.
- R6: On the clock edge that ends the `rd_n` low cycle, `adc_data` is captured. In the next cycle `buf_we` is high for one cycle, with `buf_addr` = k and `buf_wdata` holding the captured value.
- R7: A scan writes exactly `NUM_CH` samples, to addresses 0 to `NUM_CH`-1 in order. After the last one the selects stay on the final channel.
- R8: `done` is high for exactly one cycle, in the cycle after the last `buf_we`.
- R9: A start pulse while a scan is running is ignored. The scan keeps its addresses and its sample count.
- R10: If `adc_busy` is still high after `BUSY_TIMEOUT` cycles of waiting, the scan is abandoned. `wr_n` has then been low for `BUSY_TIMEOUT`+1 cycles. In the same cycle all strobes go high and `err` goes high. There is no further `buf_we` and no `done`.
- R11: `err` stays high until the next accepted start, which clears it in its first cycle and runs a full scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a scan when the sequencer is idle |
| adc_busy | input | 1 | Conversion in progress, active high |
| adc_data | input | DW | Parallel conversion result |
| cs_n | output | 1 | ADC chip select, active low |
| wr_n | output | 1 | Conversion start strobe, active low |
| rd_n | output | 1 | Result read strobe, active low |
| adc_sel | output | 3 | Which ADC is addressed |
| mux_sel | output | 3 | Multiplexer input select (bit0=A, bit1=B, bit2=C) |
| buf_we | output | 1 | Sample buffer write enable |
| buf_addr | output | $clog2(NUM_CH) | Sample buffer address |
| buf_wdata | output | DW | Sample value to store |
| done | output | 1 | One-cycle end-of-scan pulse |
| err | output | 1 | Sticky busy-timeout flag |

## Verification
A wrong scan index or select counter shows up at the next sample. The bench tags every data value with its channel and scan number, so a skipped, repeated or reordered channel gives the wrong `buf_wdata`, or a `buf_addr` that is out of step, on the very next `buf_we`. A handshake state that is entered too early or held too long changes how many cycles a strobe stays low. The bench measures each strobe width against the conversion length it programmed into the converter model, and the check fires when that strobe rises. A broken timeout counter or stop condition shows when the scan ends, through the total write count, the single `done` pulse, or when `err` rises.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH       = 36,
  parameter int CH_PER_ADC   = 8,   // at most 8 (3 select lines)
  parameter int DW           = 12,
  parameter int SETTLE_CYC   = 4,   // at least 1
  parameter int BUSY_TIMEOUT = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      adc_busy,
  input  logic [DW-1:0]             adc_data,
  output logic                      cs_n,
  output logic                      wr_n,
  output logic                      rd_n,
  output logic [2:0]                adc_sel,
  output logic [2:0]                mux_sel,
  output logic                      buf_we,
  output logic [$clog2(NUM_CH)-1:0] buf_addr,
  output logic [DW-1:0]             buf_wdata,
  output logic                      done,
  output logic                      err
);
  localparam int IW   = $clog2(NUM_CH);
  localparam int CMAX = (SETTLE_CYC > BUSY_TIMEOUT) ? SETTLE_CYC : BUSY_TIMEOUT;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_CS, ST_WR, ST_WAIT, ST_RD, ST_DONE} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  assign cs_n = !(state inside {ST_CS, ST_WR, ST_WAIT, ST_RD});
  assign wr_n = !(state inside {ST_WR, ST_WAIT});
  assign rd_n = (state != ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      adc_sel   <= '0;
      mux_sel   <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SETTLE;
          cnt     <= '0;
          idx     <= '0;
          adc_sel <= '0;
          mux_sel <= '0;
          err     <= 1'b0;
        end
        ST_SETTLE: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            state <= ST_CS;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CS: state <= ST_WR;
        ST_WR: begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: begin
          if (!adc_busy) state <= ST_RD;
          else if (cnt == CW'(BUSY_TIMEOUT - 1)) begin
            state <= ST_IDLE;
            err   <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_RD: begin
          buf_we    <= 1'b1;
          buf_addr  <= idx;
          buf_wdata <= adc_data;
          if (idx == IW'(NUM_CH - 1)) state <= ST_DONE;
          else begin
            state <= ST_SETTLE;
            cnt   <= '0;
            idx   <= idx + 1'b1;
            if (mux_sel == 3'(CH_PER_ADC - 1)) begin
              mux_sel <= '0;
              adc_sel <= adc_sel + 3'd1;
            end else mux_sel <= mux_sel + 3'd1;
          end
        end
        ST_DONE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WR_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> !cs_n); // R4
  AST_RD_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !cs_n); // R4
  AST_NO_WR_RD: assert property (@(posedge clk) disable iff (!rst_n) !(!wr_n && !rd_n)); // R4
  AST_RD_ONE:   assert property (@(posedge clk) disable iff (!rst_n) !rd_n |=> (rd_n && cs_n)); // R4
  AST_WR_TO_RD: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> (!rd_n || err)); // R5
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                  (!cs_n && !$past(cs_n)) |-> ($stable(adc_sel) && $stable(mux_sel))); // R3
  AST_WE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) buf_we |-> !$past(rd_n)); // R6
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) buf_we |-> (buf_addr <= IW'(NUM_CH - 1))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                  $rose(err) |-> (cs_n && wr_n && rd_n && !buf_we)); // R10
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int NCH = 36, CPA = 8, DW = 12, SET = 3, TMO = 20;
  localparam int IW = $clog2(NCH);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_busy = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic cs_n, wr_n, rd_n, buf_we, done, err;
  logic [2:0] adc_sel, mux_sel;
  logic [IW-1:0] buf_addr;
  logic [DW-1:0] buf_wdata;

  int checks = 0, errors = 0;
  int scan_id = 0, conv_base = 0, stuck_k = -1;
  int wcount = 0, done_cnt = 0;
  bit arm = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NCH), .CH_PER_ADC(CPA), .DW(DW), .SETTLE_CYC(SET), .BUSY_TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_busy(adc_busy), .adc_data(adc_data),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .adc_sel(adc_sel), .mux_sel(mux_sel),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .done(done), .err(err));

  function automatic logic [DW-1:0] fval(int k, int s);
    return DW'((k * 97 + s * 29 + 5) % 4096);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model and port monitor, both acting at the falling edge
  initial begin
    int settle_cnt = 0, wr_len = 0, rd_len = 0, rem = 0, lcur = 0, k = 0;
    bit cur_stuck = 0, p_cs = 1, p_wr = 1, p_rd = 1, p_we = 0, p_done = 0;
    logic [5:0] p_sel = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        adc_busy = 1'b0; p_cs = 1; p_wr = 1; p_rd = 1; p_we = 0; p_done = 0;
        p_sel = '0; settle_cnt = 0; wr_len = 0; rd_len = 0;
      end else begin
        k = adc_sel * CPA + mux_sel;
        if ({adc_sel, mux_sel} != p_sel) settle_cnt = 1;
        else if (cs_n) settle_cnt++;
        p_sel = {adc_sel, mux_sel};
        if (arm) begin settle_cnt = 0; arm = 1'b0; end
        if (!cs_n && p_cs) begin
          chk(settle_cnt == SET, "R3 settle cycles", settle_cnt, SET);
          chk(adc_sel == wcount / CPA, "R2 adc_sel", adc_sel, wcount / CPA);
          chk(mux_sel == wcount % CPA, "R2 mux_sel", mux_sel, wcount % CPA);
        end
        if (!wr_n && p_wr) chk(!p_cs, "R4 cs before wr", p_cs, 0);
        if (!wr_n) wr_len++;
        if (wr_n && !p_wr) begin
          if (cur_stuck) begin
            chk(wr_len == TMO + 1, "R10 wait length", wr_len, TMO + 1);
            chk(err == 1'b1, "R10 err", err, 1);
            chk(cs_n && rd_n, "R10 strobes released", {cs_n, rd_n}, 3);
          end else begin
            chk(wr_len == 1 + ((lcur < 1) ? 1 : lcur), "R5 wr low length", wr_len, 1 + ((lcur < 1) ? 1 : lcur));
            chk(!rd_n, "R5 rd follows wr", rd_n, 0);
          end
          wr_len = 0;
        end
        // converter model
        if (!wr_n && !cs_n) begin
          if (p_wr) begin
            cur_stuck = (k == stuck_k);
            lcur = conv_base + (k % 3);
            adc_busy = cur_stuck || (lcur > 0);
            rem = (lcur > 0) ? lcur - 1 : 0;
          end else begin
            adc_busy = cur_stuck || (rem > 0);
            if (rem > 0) rem--;
          end
        end else adc_busy = 1'b0;
        adc_data = fval(k, scan_id);
        if (!rd_n) rd_len++;
        if (rd_n && !p_rd) begin
          chk(rd_len == 1, "R4 rd width", rd_len, 1);
          chk(cs_n, "R4 cs rises with rd", cs_n, 1);
          rd_len = 0;
        end
        if (buf_we) begin
          chk(!p_rd, "R6 write after read", p_rd, 0);
          chk(buf_addr == wcount, "R6 address", buf_addr, wcount);
          chk(buf_wdata == fval(wcount, scan_id), "R2 sample data", buf_wdata, fval(wcount, scan_id));
          wcount++;
        end
        if (done) begin
          chk(p_we, "R8 done after last write", p_we, 1);
          chk(!p_done, "R8 done one cycle", p_done, 0);
          chk(wcount == NCH, "R7 sample count", wcount, NCH);
          chk(adc_sel == (NCH - 1) / CPA && mux_sel == (NCH - 1) % CPA, "R7 stops at last channel",
              adc_sel * CPA + mux_sel, NCH - 1);
          done_cnt++;
        end
        p_cs = cs_n; p_wr = wr_n; p_rd = rd_n; p_we = buf_we; p_done = done;
      end
    end
  end

  task automatic kick(bit real_start);
    @(posedge clk); #1;
    start = 1'b1;
    if (real_start) begin arm = 1'b1; scan_id++; wcount = 0; end
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_scan(int conv, bit restart_mid);
    int d0 = done_cnt;
    int guard = 0;
    conv_base = conv;
    kick(1'b1);
    chk(err == 1'b0, "R11 err cleared by start", err, 0);
    if (restart_mid) begin
      repeat (150) @(posedge clk);
      kick(1'b0);   // R9: must be ignored
    end
    while (done_cnt == d0 && guard < 5000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, restart_mid ? "R9 single done" : "R8 single done", done_cnt - d0, 1);
    chk(wcount == NCH, restart_mid ? "R9 sample count" : "R7 sample count", wcount, NCH);
  endtask

  task automatic run_stuck(int at_k);
    int d0 = done_cnt;
    int guard = 0;
    stuck_k = at_k;
    conv_base = 1;
    kick(1'b1);
    while (!err && guard < 5000) begin @(negedge clk); guard++; end
    repeat (10) @(negedge clk);
    chk(wcount == at_k, "R10 writes before abort", wcount, at_k);
    chk(done_cnt == d0, "R10 no done", done_cnt - d0, 0);
    chk(cs_n && wr_n && rd_n, "R10 idle strobes", {cs_n, wr_n, rd_n}, 7);
    chk(err == 1'b1, "R11 err sticky", err, 1);
    stuck_k = -1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n && wr_n && rd_n, "R1 strobes high", {cs_n, wr_n, rd_n}, 7);
    chk(!buf_we && !done && !err, "R1 flags low", {buf_we, done, err}, 0);
    chk(adc_sel == 0 && mux_sel == 0, "R1 selects", {adc_sel, mux_sel}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !buf_we, "R1 idle without start", {cs_n, wr_n, rd_n, buf_we}, 14);
    for (int c = 0; c < 4; c++) run_scan(c * 2, 1'b0);
    run_scan(1, 1'b1);
    run_stuck(0);
    run_scan(3, 1'b0);
    run_stuck(10);
    run_scan(0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule